// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Fetch Sequencer

This block sits on the processor side of an interrupt path. The request it receives has already won arbitration among the devices. The block first decides whether to accept it. The request is taken only when its priority is strictly greater than the priority the processor is currently running at. Otherwise the request is ignored and execution carries on undisturbed.

Once a request is taken, the block raises an acknowledge toward the device and holds it while it waits for the device to place a vector on the data bus with a valid strobe. When the vector arrives, the block forms the handler entry address as a table base plus four times the vector and issues a one-cycle handler-call strobe with that address. If no vector shows up within a fixed window after acknowledge, a one-cycle bus-error strobe is raised instead of the call. After either outcome the acknowledge drops, and a new request is considered only after a short rest.

Top module: `irq_vector_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_ack`, `call_strobe` and `bus_err` are all low.
- R2: A request with `irq_prio` strictly greater than `cur_prio`, seen while the block is idle, makes `irq_ack` high in the cycle after the edge that samples it.
- R3: A request with `irq_prio` less than or equal to `cur_prio` is ignored: `irq_ack`, `call_strobe` and `bus_err` stay low.
- R4: `irq_ack` stays high on every cycle until a vector strobe is sampled or the timeout window ends, and it is never high for more than TIMEOUT (default 16) consecutive cycles.
- R5: When `vec_valid` is sampled high while `irq_ack` is high, `call_strobe` is high for exactly one cycle in the next cycle, and `irq_ack` is low in that same cycle.
- R6: With the call strobe, `call_addr` equals TABLE_BASE + 4 × the `vec_bus` value sampled with the strobe, taken modulo 2^ADDR_W.
- R7: If `vec_valid` is not sampled during the TIMEOUT cycles of acknowledge, `bus_err` is high for one cycle right after the last of them, `irq_ack` falls in that cycle, and no call strobe is issued.
- R8: A vector strobe sampled on the last cycle of the acknowledge window still produces a handler call and no bus error.
- R9: After `irq_ack` falls, it stays low for exactly two cycles when a qualifying request is held high throughout, and rises again on the third.
- R10: A vector strobe while `irq_ack` is low has no effect: no call strobe and no bus error follow.
- R11: `call_strobe` and `bus_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Arbitrated interrupt request |
| irq_prio | input | PRIO_W | Priority of the request |
| cur_prio | input | PRIO_W | Current execution priority |
| vec_bus | input | VEC_W | Vector driven by the device |
| vec_valid | input | 1 | Strobe marking `vec_bus` as valid |
| irq_ack | output | 1 | Acknowledge to the device |
| call_strobe | output | 1 | One-cycle handler call request |
| call_addr | output | ADDR_W | Handler entry address, valid with `call_strobe` |
| bus_err | output | 1 | One-cycle bus-error strobe on vector timeout |

## Verification
The bench builds the block with a 3-bit priority, a 4-bit vector, the default 16-cycle timeout and a table base of 0x2000. These small widths allow a full sweep of all 64 request/current priority pairs, so every accept and ignore decision is checked. They also make it practical to fetch every one of the 16 vectors and check the computed addresses. Each vector delay from zero through the full window, and one cycle past it, is swept as well. This covers the last-cycle race between the vector and the timeout, the late strobe that must be ignored, and the rest interval under a request that is held high.

// File: rtl/irq_seq_pkg.sv
// Package: shared state encoding for the interrupt vector sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package irq_seq_pkg;

    // Sequencer phases: waiting, acknowledging, mandatory rest after release.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_REST = 2'd2
    } seq_state_t;

endpackage

// File: rtl/irq_accept_gate.sv
// Module: irq_accept_gate
// Decides whether an arbitrated request is strong enough to be taken.
// A request qualifies only if its priority strictly exceeds the current
// execution priority. Assumes both priorities use the same unsigned code.
module irq_accept_gate #(
    parameter int PRIO_W = 3
) (
    input  logic              req,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              take
);

    // Strict greater-than comparison gated by the request line.
    always_comb begin
        take = req && (req_prio > run_prio);
    end

endmodule

// File: rtl/irq_ack_timer.sv
// Module: irq_ack_timer
// Counts cycles spent acknowledging and flags the last one of the window.
// Assumes 'run' is high for a contiguous stretch; the count restarts at zero
// whenever 'run' is low. WINDOW must be at least 1.
module irq_ack_timer #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt;

    // Advance while acknowledging, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && (cnt != LAST_VAL)) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    // Flag the final cycle of the acknowledge window.
    always_comb begin
        last = run && (cnt == LAST_VAL);
    end

endmodule

// File: rtl/irq_vec_addr.sv
// Module: irq_vec_addr
// Forms the handler entry address from a vector: table base plus four bytes
// per entry. Assumes ADDR_W is wide enough to hold a shifted vector; the sum
// wraps modulo 2^ADDR_W.
module irq_vec_addr #(
    parameter int              VEC_W      = 8,
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);

    localparam int ENTRY_SHIFT = 2;

    // Scale the vector to a word offset and add the table base.
    always_comb begin
        addr = TABLE_BASE + (ADDR_W'(vec) << ENTRY_SHIFT);
    end

endmodule

// File: rtl/irq_vector_seq.sv
// Module: irq_vector_seq (top)
// Accepts a priority-qualified interrupt request, acknowledges it, waits up
// to TIMEOUT cycles for a vector and then issues either a handler call with
// the table address or a bus error. Assumes arbitration among devices is done
// upstream and that vec_bus is stable whenever vec_valid is high.
module irq_vector_seq #(
    parameter int                PRIO_W     = 3,
    parameter int                VEC_W      = 8,
    parameter int                ADDR_W     = 32,
    parameter int                TIMEOUT    = 16,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [VEC_W-1:0]  vec_bus,
    input  logic              vec_valid,
    output logic              irq_ack,
    output logic              call_strobe,
    output logic [ADDR_W-1:0] call_addr,
    output logic              bus_err
);

    import irq_seq_pkg::*;

    seq_state_t        state, state_nx;
    logic              take;
    logic              window_last;
    logic              in_ack;
    logic [ADDR_W-1:0] entry_addr;

    assign in_ack = (state == ST_ACK);

    irq_accept_gate #(
        .PRIO_W (PRIO_W)
    ) u_gate (
        .req      (irq_req),
        .req_prio (irq_prio),
        .run_prio (cur_prio),
        .take     (take)
    );

    irq_ack_timer #(
        .WINDOW (TIMEOUT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_ack),
        .last  (window_last)
    );

    irq_vec_addr #(
        .VEC_W      (VEC_W),
        .ADDR_W     (ADDR_W),
        .TABLE_BASE (TABLE_BASE)
    ) u_addr (
        .vec  (vec_bus),
        .addr (entry_addr)
    );

    // Next-phase selection: vector wins over timeout on the final cycle.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take) state_nx = ST_ACK;
            ST_ACK:  if (vec_valid || window_last) state_nx = ST_REST;
            ST_REST: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Result strobes and captured handler address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_strobe <= 1'b0;
            bus_err     <= 1'b0;
            call_addr   <= '0;
        end else begin
            call_strobe <= in_ack && vec_valid;
            bus_err     <= in_ack && !vec_valid && window_last;
            if (in_ack && vec_valid) call_addr <= entry_addr;
        end
    end

    // Acknowledge is a direct decode of the phase register.
    always_comb begin
        irq_ack = in_ack;
    end

endmodule

// File: rtl/irq_vector_seq_checker.sv
// Module: irq_vector_seq_checker
// Temporal properties of the sequencer ports, attached by bind. Assumes the
// same parameters as the instance it watches.
module irq_vector_seq_checker #(
    parameter int                PRIO_W     = 3,
    parameter int                VEC_W      = 8,
    parameter int                ADDR_W     = 32,
    parameter int                TIMEOUT    = 16,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 32'h0000_1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic [PRIO_W-1:0] irq_prio,
    input logic [PRIO_W-1:0] cur_prio,
    input logic [VEC_W-1:0]  vec_bus,
    input logic              vec_valid,
    input logic              irq_ack,
    input logic              call_strobe,
    input logic [ADDR_W-1:0] call_addr,
    input logic              bus_err
);

    localparam int RUN_W = $clog2(TIMEOUT + 2) + 1;

    logic [RUN_W-1:0] ack_run;
    logic             seen_clk;

    // Count consecutive acknowledge cycles already elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_run <= '0;
        else if (irq_ack) ack_run <= ack_run + 1'b1;
        else              ack_run <= '0;
    end

    // Marks that at least one post-reset edge has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_clk <= 1'b0;
        else        seen_clk <= 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        (rst_n && !seen_clk) |-> (!irq_ack && !call_strobe && !bus_err));

    a_r2_ack_needs_higher_prio: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> $past(irq_req && (irq_prio > cur_prio)));

    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (ack_run < RUN_W'(TIMEOUT)));

    a_r4_release_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ack) |-> (call_strobe || bus_err));

    a_r5_call_follows_vector: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe |-> ($past(irq_ack) && $past(vec_valid) && !irq_ack));

    a_r6_call_address: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe |-> (call_addr == TABLE_BASE + (ADDR_W'($past(vec_bus)) << 2)));

    a_r7_error_after_silence: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(irq_ack) && !$past(vec_valid) && !irq_ack));

    a_r9_rest_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ack) |=> !irq_ack);

    a_r11_exclusive_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(call_strobe && bus_err));

endmodule

bind irq_vector_seq irq_vector_seq_checker #(
    .PRIO_W     (PRIO_W),
    .VEC_W      (VEC_W),
    .ADDR_W     (ADDR_W),
    .TIMEOUT    (TIMEOUT),
    .TABLE_BASE (TABLE_BASE)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_prio    (irq_prio),
    .cur_prio    (cur_prio),
    .vec_bus     (vec_bus),
    .vec_valid   (vec_valid),
    .irq_ack     (irq_ack),
    .call_strobe (call_strobe),
    .call_addr   (call_addr),
    .bus_err     (bus_err)
);

// File: tb/irq_vector_seq_test.sv
// Bench for irq_vector_seq: sweeps priorities, vectors and vector delays.
module irq_vector_seq_test;

    localparam int          PRIO_W  = 3;
    localparam int          VEC_W   = 4;
    localparam int          ADDR_W  = 32;
    localparam int          TIMEOUT = 16;
    localparam logic [31:0] BASE    = 32'h0000_2000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_req = 1'b0;
    logic [PRIO_W-1:0] irq_prio = '0;
    logic [PRIO_W-1:0] cur_prio = '0;
    logic [VEC_W-1:0]  vec_bus = '0;
    logic              vec_valid = 1'b0;
    logic              irq_ack;
    logic              call_strobe;
    logic [ADDR_W-1:0] call_addr;
    logic              bus_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    irq_vector_seq #(
        .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
        .TIMEOUT(TIMEOUT), .TABLE_BASE(BASE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
        .cur_prio(cur_prio), .vec_bus(vec_bus), .vec_valid(vec_valid),
        .irq_ack(irq_ack), .call_strobe(call_strobe), .call_addr(call_addr),
        .bus_err(bus_err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint actual, input longint expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    // One request: drive at a falling edge, vector after 'dly' ack cycles.
    task automatic one_req(input int p, input int c, input int v, input int dly);
        bit take;
        longint exp_addr;
        take = (p > c);
        exp_addr = longint'(BASE) + longint'(v) * 4;
        @(negedge clk);
        irq_req = 1'b1; irq_prio = PRIO_W'(p); cur_prio = PRIO_W'(c);
        @(negedge clk);
        irq_req = 1'b0;
        if (!take) begin
            for (int k = 0; k < 3; k++) begin
                check(!irq_ack && !call_strobe && !bus_err, "R3", "ignored request",
                      {irq_ack, call_strobe, bus_err}, 0);
                @(negedge clk);
            end
            return;
        end
        check(irq_ack, "R2", "ack after qualifying request", irq_ack, 1);
        for (int i = 0; i < TIMEOUT; i++) begin
            check(irq_ack, "R4", "ack held while waiting", irq_ack, 1);
            if (i == dly) begin
                vec_valid = 1'b1; vec_bus = VEC_W'(v);
            end
            @(negedge clk);
            vec_valid = 1'b0;
            if (i == dly) begin
                check(call_strobe, (dly == TIMEOUT - 1) ? "R8" : "R5", "call strobe",
                      call_strobe, 1);
                check(!irq_ack, "R5", "ack released with call", irq_ack, 0);
                check(call_addr == exp_addr[ADDR_W-1:0], "R6", "handler address",
                      call_addr, exp_addr[ADDR_W-1:0]);
                check(!bus_err, "R11", "no error with call", bus_err, 0);
                @(negedge clk);
                check(!call_strobe, "R5", "call lasts one cycle", call_strobe, 0);
                return;
            end
        end
        check(bus_err, "R7", "bus error on timeout", bus_err, 1);
        check(!call_strobe, "R7", "no call on timeout", call_strobe, 0);
        check(!irq_ack, "R7", "ack released on timeout", irq_ack, 0);
        if (dly == TIMEOUT) begin
            vec_valid = 1'b1; vec_bus = VEC_W'(v);
        end
        @(negedge clk);
        vec_valid = 1'b0;
        check(!call_strobe && !bus_err, "R10", "late vector ignored",
              {call_strobe, bus_err}, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!irq_ack && !call_strobe && !bus_err, "R1", "outputs in reset",
              {irq_ack, call_strobe, bus_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!irq_ack && !call_strobe && !bus_err, "R1", "outputs after reset",
              {irq_ack, call_strobe, bus_err}, 0);

        // R2/R3: every request/current priority pair.
        for (int p = 0; p < (1 << PRIO_W); p++)
            for (int c = 0; c < (1 << PRIO_W); c++)
                one_req(p, c, (p * 3 + c) % (1 << VEC_W), (p + c) % 4);

        // R6: every vector value.
        for (int v = 0; v < (1 << VEC_W); v++)
            one_req(5, 1, v, 0);

        // R4/R7/R8/R10: every delay through and one past the window.
        for (int d = 0; d <= TIMEOUT; d++)
            one_req(7, 0, 9, d);

        // R10: strobe while idle.
        @(negedge clk);
        vec_valid = 1'b1; vec_bus = 4'd3;
        @(negedge clk);
        vec_valid = 1'b0;
        check(!call_strobe && !bus_err && !irq_ack, "R10", "idle vector ignored",
              {irq_ack, call_strobe, bus_err}, 0);

        // R9: request held high across a completed call.
        @(negedge clk);
        irq_req = 1'b1; irq_prio = 3'd6; cur_prio = 3'd2;
        @(negedge clk);
        check(irq_ack, "R9", "first ack", irq_ack, 1);
        vec_valid = 1'b1; vec_bus = 4'd1;
        @(negedge clk);
        vec_valid = 1'b0;
        check(!irq_ack && call_strobe, "R9", "release with call",
              {irq_ack, call_strobe}, 1);
        @(negedge clk);
        check(!irq_ack, "R9", "second rest cycle", irq_ack, 0);
        @(negedge clk);
        check(irq_ack, "R9", "re-ack after rest", irq_ack, 1);
        irq_req = 1'b0;
        repeat (TIMEOUT + 3) @(negedge clk);
        check(!irq_ack, "R9", "idle after timeout", irq_ack, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule